// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block collects a wide vector of level-sensitive interrupt requests and folds them into one request line per group of eight. Each group line goes to a parent interrupt controller. Software chooses which inputs may take part by writing an enable mask, and it finds the source of a request by reading a masked status word.

Four groups share one 32-bit register bank, and each group owns one byte lane of it. Banks sit 0x10 apart in the address space. Enables change only through write-one-to-set and write-one-to-clear words. Because of this, two agents can change different bits without a read-modify-write race. The number of groups is a parameter; the default is 20 groups, which gives 160 inputs and 5 banks.

Top module: `irq_group_merge`

## Requirements
- R1: While reset is asserted and right after it, every enable bit is 0, every group output is 0 and the read data is 0.
- R2: A write to word offset 0x0 of a bank ORs the write data into that bank's enable bits; 0 bits in the data leave enables unchanged. A read of offset 0x0 returns the bank's enable bits.
- R3: A write to offset 0x4 of a bank clears every enable bit whose data bit is 1; 0 bits leave enables unchanged. A read of offset 0x4 returns 0.
- R4: A read of offset 0xC returns the registered input levels of the bank ANDed with its enable bits, so masked inputs read as 0.
- R5: Group output g is the OR of the eight enabled, registered inputs of group g. It stays high for as long as any such input is held high.
- R6: Global input index g*8+line (line 0..7) belongs to group g. Group g is controlled by bank g/4 at base address 0x10*(g/4), in bits [8*(g%4)+7 : 8*(g%4)] of that bank's words.
- R7: An input change sampled at a rising edge, or an enable write taken at a rising edge, shows on the group outputs right after that same edge and not before it.
- R8: Read data is loaded at a rising edge where the read enable is high and holds its value at all other edges.
- R9: Offset 0x8 and any bank at or above the bank count read as 0, and writes to them change no enable bit. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_GROUPS*8 | Level interrupt requests, index g*8+line |
| addr | input | ADDR_W | Byte address: bank in [ADDR_W-1:4], word in [3:2] |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| grp_irq | output | NUM_GROUPS | One request line per group |

## Verification
The group outputs are driven with inputs that are all masked, with a single enabled line, with two enabled lines in different groups, and with a line held high over several cycles. These patterns separate a masked OR from a raw OR and show that the output is a level, not a pulse. Set and clear writes with mixed 0 and 1 bits separate true write-one semantics from a plain overwrite. Groups in the upper byte lanes and in the last bank confirm the bank and lane mapping, which a low-group-only test would miss. Checks taken half a cycle before and after the edge pin the single-edge latency of both an input change and an enable change.

// File: rtl/irq_group_merge.sv
module irq_group_merge #(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_GROUPS*8-1:0] irq_in,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [31:0]             wdata,
  input  logic                    wr_en,
  input  logic                    rd_en,
  output logic [31:0]             rdata,
  output logic [NUM_GROUPS-1:0]   grp_irq
);
  localparam int NUM_IN    = NUM_GROUPS * 8;
  localparam int NUM_BANKS = (NUM_GROUPS + 3) / 4;
  localparam int PAD       = NUM_BANKS * 32;
  localparam logic [PAD-1:0] LIVE = PAD'({NUM_IN{1'b1}});

  logic [PAD-1:0]      lvl_q, en_q, stat, set_v, clr_v;
  logic [31:0]         rd_val;
  logic [1:0]          word;
  logic [ADDR_W-5:0]   bank;

  assign word = addr[3:2];
  assign bank = addr[ADDR_W-1:4];
  assign stat = lvl_q & en_q;

  always_comb begin
    set_v  = '0;
    clr_v  = '0;
    rd_val = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(bank) == b) begin
        if (wr_en && word == 2'd0) set_v[b*32 +: 32] = wdata;
        if (wr_en && word == 2'd1) clr_v[b*32 +: 32] = wdata;
        if (word == 2'd0) rd_val = en_q[b*32 +: 32];
        if (word == 2'd3) rd_val = stat[b*32 +: 32];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      en_q  <= '0;
      rdata <= '0;
    end else begin
      lvl_q <= PAD'(irq_in);
      en_q  <= (en_q | set_v) & ~clr_v & LIVE;
      if (rd_en) rdata <= rd_val;
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_or
    assign grp_irq[g] = |stat[g*8 +: 8];
  end
endmodule

module irq_group_merge_chk #(
  parameter int NUM_GROUPS = 20,
  parameter int ADDR_W     = 8
)(
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_GROUPS*8-1:0] irq_in,
  input logic [ADDR_W-1:0]       addr,
  input logic [31:0]             wdata,
  input logic                    wr_en,
  input logic                    rd_en,
  input logic [31:0]             rdata,
  input logic [NUM_GROUPS-1:0]   grp_irq
);
  // R3
  clr_word_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr[3:2] == 2'd1 |=> rdata == 32'h0);

  // R9
  hole_word_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr[3:2] == 2'd2 |=> rdata == 32'h0);

  // R8
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  // R3
  clr_drops_grp0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr[3:2] == 2'd1 && addr[ADDR_W-1:4] == '0 && wdata[7:0] == 8'hFF
    |=> !grp_irq[0]);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_src
    // R5
    grp_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grp_irq[g] |-> $past(irq_in[g*8 +: 8]) != 8'h0);
  end
endmodule

bind irq_group_merge irq_group_merge_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wdata(wdata),
  .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .grp_irq(grp_irq)
);

// File: tb/test_irq_group_merge.sv
module test_irq_group_merge;
  localparam int NG = 20;
  localparam int AW = 8;
  localparam int NI = NG * 8;
  localparam int NB = (NG + 3) / 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NI-1:0] irq_in = '0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [31:0]   rdata;
  logic [NG-1:0] grp_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;
  logic [NI-1:0] en_m = '0;

  always #10 clk = ~clk;

  irq_group_merge #(.NUM_GROUPS(NG), .ADDR_W(AW)) i_irq_group_merge (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata), .grp_irq(grp_irq)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_grp();
    logic [31:0] r = '0;
    for (int g = 0; g < NG; g++) r[g] = |(irq_in[g*8 +: 8] & en_m[g*8 +: 8]);
    return r;
  endfunction

  task automatic wr(logic [7:0] a, logic [31:0] d);
    int b = int'(a[7:4]);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (b < NB && a[3:2] == 2'd0) en_m[b*32 +: 32] = en_m[b*32 +: 32] | d;
    if (b < NB && a[3:2] == 2'd1) en_m[b*32 +: 32] = en_m[b*32 +: 32] & ~d;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic put(logic [NI-1:0] v);
    @(negedge clk);
    irq_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    chk("R1", "grp in reset", 32'(grp_irq), 32'h0);
    chk("R1", "rdata in reset", rdata, 32'h0);
    rst_n = 1'b1;
    for (int b = 0; b < NB; b++) begin
      rd(8'(b * 16), v);
      chk("R1", "enable after reset", v, 32'h0);
    end
    chk("R1", "grp after reset", 32'(grp_irq), 32'h0);
  endtask

  task automatic t_set();
    logic [31:0] v;
    wr(8'h00, 32'h0000_00A5);
    rd(8'h00, v);
    chk("R2", "set readback", v, 32'h0000_00A5);
    wr(8'h00, 32'h0000_0100);
    rd(8'h00, v);
    chk("R2", "set keeps other bits", v, 32'h0000_01A5);
    wr(8'h00, 32'h0);
    rd(8'h00, v);
    chk("R2", "zero set no effect", v, 32'h0000_01A5);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(8'h04, 32'h0000_0005);
    rd(8'h00, v);
    chk("R3", "clear selected bits", v, 32'h0000_01A0);
    rd(8'h04, v);
    chk("R3", "clear word reads 0", v, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] v;
    put(NI'(32'h0000_00F0));
    rd(8'h0C, v);
    chk("R4", "status masked 0xF0", v, 32'h0000_00A0);
    put(NI'(32'h0000_0300));
    rd(8'h0C, v);
    chk("R4", "status masked 0x300", v, 32'h0000_0100);
  endtask

  task automatic t_or();
    put(NI'(32'h0000_005F));
    chk("R5", "only masked lines", 32'(grp_irq), 32'h0);
    put(NI'(32'h0000_0080));
    chk("R5", "one enabled line", 32'(grp_irq), 32'h1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5", "level held", 32'(grp_irq), 32'h1);
    end
    put(NI'(32'h0000_0180));
    chk("R5", "two groups", 32'(grp_irq), 32'h3);
    put('0);
    chk("R5", "all low", 32'(grp_irq), 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    logic [NI-1:0] p;
    wr(8'h30, 32'h0000_2000);
    p = '0; p[13*8 + 5] = 1'b1;
    put(p);
    chk("R6", "group 13 line 5", 32'(grp_irq), 32'h0000_2000);
    rd(8'h3C, v);
    chk("R6", "bank 3 status lane 1", v, 32'h0000_2000);
    wr(8'h40, 32'h8000_0000);
    p = '0; p[159] = 1'b1;
    put(p);
    chk("R6", "group 19 line 7", 32'(grp_irq), 32'h0008_0000);
    chk("R6", "model agrees", 32'(grp_irq), exp_grp());
    put('0);
  endtask

  task automatic t_latency();
    @(negedge clk);
    irq_in = NI'(32'h0000_0080);
    #5;
    chk("R7", "input before edge", 32'(grp_irq), 32'h0);
    @(negedge clk);
    chk("R7", "input after edge", 32'(grp_irq), 32'h1);
    addr = 8'h04; wdata = 32'h0000_0080; wr_en = 1'b1;
    #5;
    chk("R7", "enable before edge", 32'(grp_irq), 32'h1);
    @(negedge clk);
    wr_en = 1'b0;
    en_m[7] = 1'b0;
    chk("R7", "enable after edge", 32'(grp_irq), 32'h0);
    put('0);
  endtask

  task automatic t_rdhold();
    logic [31:0] v;
    rd(8'h0C, v);
    chk("R8", "status idle", v, 32'h0);
    put(NI'(32'h0000_0100));
    @(negedge clk);
    chk("R8", "rdata holds", rdata, 32'h0);
    rd(8'h0C, v);
    chk("R8", "new read loads", v, 32'h0000_0100);
    put('0);
  endtask

  task automatic t_unmap();
    logic [31:0] v;
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'hF4, 32'hFFFF_FFFF);
    wr(8'h01, 32'h0000_0001);
    rd(8'h08, v);
    chk("R9", "hole word read", v, 32'h0);
    rd(8'h50, v);
    chk("R9", "bank 5 read", v, 32'h0);
    rd(8'h5C, v);
    chk("R9", "bank 5 status read", v, 32'h0);
    for (int b = 0; b < NB; b++) begin
      rd(8'(b * 16), v);
      chk("R9", "enables untouched", v, en_m[b*32 +: 32]);
    end
  endtask

  initial begin
    t_reset();
    t_set();
    t_clear();
    t_status();
    t_or();
    t_map();
    t_latency();
    t_rdhold();
    t_unmap();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule